// File: doc/BRIEF.md
# TDC Channel Hit Capture

This block is one channel of a time-to-digital converter that sits behind a tapped delay line. The delay line is presented as a vector of tap states. A hit runs along the taps, and the tap states are latched on the first system clock edge after the hit. The block keeps a free-running coarse counter that advances once per clock. It detects each new hit from a change of the first tap. It locates the propagating edge in the latched tap vector and turns that position into a binary fine time. It then packs the fine time with the coarse count of the same clock and pushes the word into a small first-word-fall-through FIFO for readout.

The delay line spans more than one clock period, so every hit inside a cycle lands on the line. A hit of either polarity is handled: a falling edge is measured on the inverted pattern. A single-tap bubble is removed by majority-of-three smoothing before the edge position is found. A trigger bus can switch the channel's tap source to a second delay line. That line is fed by an oscillator that is not correlated with the clock and collects calibration hits. The interval between hits on two channels is the difference of their combined coarse-and-fine values.

Top module: `tdc_channel`

## Requirements
- R1: While rst_n is low and on the first cycle after it, `empty`=1, `full`=0 and `overflow`=0.
- R2: A hit is recorded only when tap 0 of the latched snapshot differs from tap 0 of the previous snapshot. A pattern change that leaves tap 0 unchanged writes nothing. At most one hit is recorded per clock.
- R3: For a rising hit (taps 0..k are 1 and higher taps are 0), the fine field is k. A snapshot of all ones gives TAPS-1.
- R4: For a falling hit (tap 0 goes from 1 to 0), the snapshot is inverted before encoding. Taps 0..k at 0 with higher taps at 1 give fine k.
- R5: Each tap is replaced by the majority of itself and its two neighbours before encoding, with tap -1 taken as 1 and tap TAPS as 0. A lone 0 inside the ones, or a lone 1 above them, does not move the result.
- R6: The output word holds the fine time in bits [FINE_W-1:0] and the coarse count in the bits above. The coarse count is 0 on the first clock after reset and increments by one each clock, wrapping at 2^COARSE_W. The stored coarse count is the value at the edge that latched the taps.
- R7: The word from a hit appears at `rd_data` with `empty`=0 two clock edges after its taps are presented. Words leave in arrival order. `rd_en` with `empty`=0 pops one word at the next edge. `rd_en` while empty has no effect.
- R8: After DEPTH (16) unread hits, `full`=1. A further hit is dropped and sets `overflow`, which stays at 1 until reset. The stored words are unchanged.
- R9: A cycle with `trig_valid`=1 and `trig_type`=4'hD makes the channel take its taps from `cal_taps`, from the following snapshot on. A valid trigger of any other type returns it to `phys_taps`. With `trig_valid`=0 the trigger is ignored. The unselected tap input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; its edges latch the taps |
| rst_n | input | 1 | Synchronous active-low reset |
| phys_taps | input | TAPS (32) | Tap states of the delay line driven by the measured signal |
| cal_taps | input | TAPS (32) | Tap states of the delay line driven by the calibration oscillator |
| trig_valid | input | 1 | Qualifies `trig_type` for one cycle |
| trig_type | input | 4 | Trigger type code; 4'hD selects calibration |
| rd_en | input | 1 | Pop the head word of the FIFO |
| rd_data | output | COARSE_W+FINE_W (16) | Head word: coarse count high, fine time low |
| empty | output | 1 | FIFO holds no word |
| full | output | 1 | FIFO holds DEPTH words |
| overflow | output | 1 | Sticky: a hit was dropped because the FIFO was full |

## Verification
The checker watches the flag behaviour on every cycle:
- the overflow flag stays set once it is set;
- full and empty are never high together;
- full holds without a pop and clears with one;
- an empty FIFO stays empty in a cycle with no hit;
- a hit always leaves a word behind;
- the coarse counter steps by exactly one per clock.

The values inside the words can only be shown by the bench's scenarios. These are the fine code for rising, falling and bubbled patterns, the coarse tag across the counter wrap, the order of the words, and the words kept and dropped around overflow. The bench also shows the switch between the physical and calibration tap sources and its ignored inputs.

// File: rtl/tdc_pkg.sv
// Package: shared constants and helpers for the TDC channel.
// Assumes nothing beyond IEEE 1800-2017.
package tdc_pkg;

    // Trigger type code that routes the calibration delay line to the channel.
    localparam logic [3:0] CAL_TRIG_CODE = 4'hD;

    // Majority of three bits, used to smooth single-tap bubbles.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tdc_tap_capture.sv
// Tap capture: picks the tap source (physical or calibration), latches a
// snapshot on every clock together with the free-running coarse count, and
// flags a hit when tap 0 changed relative to the previous snapshot.
// Assumes the tap inputs settle before each clock edge (delay line model).
module tdc_tap_capture
    import tdc_pkg::*;
#(
    parameter int TAPS     = 32,
    parameter int COARSE_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TAPS-1:0]     phys_taps,
    input  logic [TAPS-1:0]     cal_taps,
    input  logic                trig_valid,
    input  logic [3:0]          trig_type,
    output logic [TAPS-1:0]     snap,
    output logic [COARSE_W-1:0] snap_coarse,
    output logic [COARSE_W-1:0] coarse_now,
    output logic                hit
);

    logic            cal_mode;
    logic            prev_tap0;
    logic [TAPS-1:0] src_taps;

    // Source selection register: updated only by a qualified trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cal_mode <= 1'b0;
        else if (trig_valid)
            cal_mode <= (trig_type == CAL_TRIG_CODE);
    end

    // Tap source mux feeding the snapshot register.
    always_comb begin
        src_taps = cal_mode ? cal_taps : phys_taps;
    end

    // Snapshot, coarse tag and previous tap-0 history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap        <= '0;
            snap_coarse <= '0;
            coarse_now  <= '0;
            prev_tap0   <= 1'b0;
        end else begin
            snap        <= src_taps;
            snap_coarse <= coarse_now;
            coarse_now  <= coarse_now + 1'b1;
            prev_tap0   <= snap[0];
        end
    end

    // Hit flag: tap 0 moved since the last snapshot.
    always_comb begin
        hit = snap[0] ^ prev_tap0;
    end

endmodule

// File: rtl/tdc_thermo_encoder.sv
// Thermometer encoder: normalises the snapshot polarity on tap 0, smooths
// single-tap bubbles by majority of three, and reports the index of the
// last 1 before the first 0. Assumes tap 0 marks the hit polarity.
module tdc_thermo_encoder
    import tdc_pkg::*;
#(
    parameter int TAPS   = 32,
    parameter int FINE_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]   snap,
    output logic [FINE_W-1:0] fine
);

    logic [TAPS-1:0] norm;
    logic [TAPS-1:0] smooth;

    // Polarity normalisation: a falling hit is measured on the inverse.
    always_comb begin
        norm = snap[0] ? snap : ~snap;
    end

    // Bubble suppression, with a 1 below tap 0 and a 0 above the top tap.
    genvar g;
    generate
        for (g = 0; g < TAPS; g++) begin : g_smooth
            if (g == 0) begin : g_lo
                assign smooth[g] = maj3(1'b1, norm[g], norm[g+1]);
            end else if (g == TAPS - 1) begin : g_hi
                assign smooth[g] = maj3(norm[g-1], norm[g], 1'b0);
            end else begin : g_mid
                assign smooth[g] = maj3(norm[g-1], norm[g], norm[g+1]);
            end
        end
    endgenerate

    // Position: one below the lowest 0, or the top tap if none.
    always_comb begin
        fine = FINE_W'(TAPS - 1);
        for (int i = TAPS - 1; i >= 1; i--) begin
            if (!smooth[i])
                fine = FINE_W'(i - 1);
        end
    end

endmodule

// File: rtl/tdc_hit_fifo.sv
// Hit FIFO: first-word-fall-through storage with full/empty flags and a
// sticky overflow flag; writes while full are dropped.
// Assumes DEPTH is a power of two.
module tdc_hit_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             overflow
);

    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wptr;
    logic [AW:0]      rptr;
    logic             do_wr;
    logic             do_rd;

    // Flags and qualified strobes.
    always_comb begin
        empty   = (wptr == rptr);
        full    = (wptr - rptr) == (AW + 1)'(DEPTH);
        do_wr   = wr_en && !full;
        do_rd   = rd_en && !empty;
        rd_data = mem[rptr[AW-1:0]];
    end

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wptr[AW-1:0]] <= wr_data;
    end

    // Pointers and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr)
                wptr <= wptr + 1'b1;
            if (do_rd)
                rptr <= rptr + 1'b1;
            if (wr_en && full)
                overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/tdc_channel.sv
// TDC channel top: tap capture, thermometer encoding and hit FIFO.
// Output word = {coarse count at tap latch, fine edge position}.
// Assumes taps are presented settled before each clock edge.
module tdc_channel #(
    parameter int TAPS     = 32,
    parameter int COARSE_W = 11,
    parameter int DEPTH    = 16,
    localparam int FINE_W  = $clog2(TAPS),
    localparam int WORD_W  = COARSE_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAPS-1:0]   phys_taps,
    input  logic [TAPS-1:0]   cal_taps,
    input  logic              trig_valid,
    input  logic [3:0]        trig_type,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              overflow
);

    logic [TAPS-1:0]     snap;
    logic [COARSE_W-1:0] snap_coarse;
    logic [COARSE_W-1:0] coarse_now;
    logic                hit;
    logic [FINE_W-1:0]   fine;
    logic [WORD_W-1:0]   hit_word;

    tdc_tap_capture #(.TAPS(TAPS), .COARSE_W(COARSE_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .phys_taps   (phys_taps),
        .cal_taps    (cal_taps),
        .trig_valid  (trig_valid),
        .trig_type   (trig_type),
        .snap        (snap),
        .snap_coarse (snap_coarse),
        .coarse_now  (coarse_now),
        .hit         (hit)
    );

    tdc_thermo_encoder #(.TAPS(TAPS), .FINE_W(FINE_W)) u_encoder (
        .snap (snap),
        .fine (fine)
    );

    // Word packing: coarse tag high, fine time low.
    always_comb begin
        hit_word = {snap_coarse, fine};
    end

    tdc_hit_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hit),
        .wr_data  (hit_word),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .empty    (empty),
        .full     (full),
        .overflow (overflow)
    );

endmodule

// File: rtl/tdc_channel_checker.sv
// Checker: cycle-level properties of the TDC channel flags and counter.
// Bound into tdc_channel below; observes only.
module tdc_channel_checker #(
    parameter int COARSE_W = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hit,
    input logic                rd_en,
    input logic                empty,
    input logic                full,
    input logic                overflow,
    input logic [COARSE_W-1:0] coarse_now
);

    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_full_empty_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);

    assert_pop_leaves_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_en) |=> !full);

    assert_quiet_stays_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !hit) |=> empty);

    assert_hit_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && empty) |=> !empty);

    assert_coarse_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (coarse_now == $past(coarse_now) + 1'b1));

endmodule

bind tdc_channel tdc_channel_checker #(.COARSE_W(COARSE_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .rd_en      (rd_en),
    .empty      (empty),
    .full       (full),
    .overflow   (overflow),
    .coarse_now (coarse_now)
);

// File: tb/tdc_channel_test.sv
`timescale 1ns/1ps
// Directed bench for tdc_channel; one task per scenario.
module tdc_channel_test;

    localparam int TAPS = 32;
    localparam int CW   = 11;
    localparam int FW   = 5;
    localparam int WW   = CW + FW;
    localparam int CMOD = 1 << CW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TAPS-1:0] phys_taps = '0;
    logic [TAPS-1:0] cal_taps = '0;
    logic            trig_valid = 1'b0;
    logic [3:0]      trig_type = 4'h0;
    logic            rd_en = 1'b0;
    logic [WW-1:0]   rd_data;
    logic            empty, full, overflow;

    int total = 0;
    int bad = 0;
    int tb_cyc = 0;
    bit done = 0;

    tdc_channel uut (
        .clk(clk), .rst_n(rst_n), .phys_taps(phys_taps), .cal_taps(cal_taps),
        .trig_valid(trig_valid), .trig_type(trig_type), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty), .full(full), .overflow(overflow)
    );

    always #2 clk = ~clk;

    // Bench cycle count since reset release (expected coarse value).
    always @(posedge clk) begin
        if (!rst_n) tb_cyc <= 0;
        else        tb_cyc <= tb_cyc + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int word(input int coarse, input int fine);
        return ((coarse % CMOD) << FW) | fine;
    endfunction

    // Present a phys pattern; return the expected coarse tag; wait until stored.
    task automatic present(input logic [TAPS-1:0] p, output int exp_c);
        @(negedge clk);
        phys_taps = p;
        exp_c = tb_cyc;
        repeat (2) @(negedge clk);
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain();
        while (!empty) pop();
    endtask

    task automatic t_reset();
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 overflow", overflow, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 empty after release", empty, 1);
        check("R1 overflow after release", overflow, 0);
        pop();
        check("R7 pop on empty ignored", empty, 1);
    endtask

    task automatic t_rising();
        int c;
        present(32'h0000_000F, c);
        check("R7 word visible", empty, 0);
        check("R3 rising k=3", rd_data, word(c, 3));
        pop();
        check("R7 pop empties", empty, 1);
        present(32'h0000_00FF, c);
        check("R2 tap0 unchanged no hit", empty, 1);
        present(32'h0000_0000, c);
        drain();
        present(32'hFFFF_FFFF, c);
        check("R3 all ones", rd_data, word(c, TAPS - 1));
        pop();
    endtask

    task automatic t_falling();
        int c;
        present(32'hFFFF_E000, c);
        check("R4 falling k=12", rd_data, word(c, 12));
        pop();
    endtask

    task automatic t_bubble();
        int c;
        present(32'h0000_03DF, c);
        check("R5 inner bubble", rd_data, word(c, 9));
        pop();
        present(32'h0000_0000, c);
        drain();
        present(32'h0000_13FF, c);
        check("R5 stray one", rd_data, word(c, 9));
        pop();
        present(32'h0000_0000, c);
        drain();
    endtask

    task automatic t_order_wrap();
        int c0;
        int c1;
        while ((tb_cyc % CMOD) != CMOD - 1) @(negedge clk);
        c0 = tb_cyc;
        phys_taps = 32'h0000_0001;
        @(negedge clk);
        c1 = tb_cyc;
        phys_taps = 32'h0000_0000;
        repeat (2) @(negedge clk);
        check("R6 coarse before wrap", int'(rd_data[WW-1:FW]), c0 % CMOD);
        check("R7 first word first", rd_data, word(c0, 0));
        pop();
        check("R6 coarse wraps to 0", int'(rd_data[WW-1:FW]), 0);
        check("R4 second word all-zero fall", rd_data, word(c1, TAPS - 1));
        pop();
        check("R7 empty after two pops", empty, 1);
    endtask

    task automatic t_overflow();
        int c0;
        @(negedge clk);
        c0 = tb_cyc;
        for (int i = 0; i < 16; i++) begin
            phys_taps = (i % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000;
            @(negedge clk);
        end
        @(negedge clk);
        check("R8 full after 16", full, 1);
        check("R8 no overflow yet", overflow, 0);
        phys_taps = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        check("R8 overflow set", overflow, 1);
        check("R8 first kept", rd_data, word(c0, TAPS - 1));
        for (int i = 0; i < 15; i++) pop();
        check("R8 last kept word", rd_data, word(c0 + 15, TAPS - 1));
        pop();
        check("R8 dropped word absent", empty, 1);
        check("R8 overflow sticky", overflow, 1);
        phys_taps = 32'h0000_0000;
        repeat (2) @(negedge clk);
        drain();
    endtask

    task automatic t_calib();
        int c;
        cal_taps = 32'h0000_000F;
        trig_type = 4'hD;
        trig_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 unqualified trigger ignored", empty, 1);
        trig_valid = 1'b1;
        @(negedge clk);
        trig_valid = 1'b0;
        trig_type = 4'h0;
        c = tb_cyc;
        repeat (2) @(negedge clk);
        check("R9 calibration source hit", rd_data, word(c, 3));
        pop();
        phys_taps = 32'h0000_00FF;
        repeat (3) @(negedge clk);
        check("R9 phys ignored in cal mode", empty, 1);
        cal_taps = 32'h0000_0000;
        repeat (3) @(negedge clk);
        drain();
        trig_type = 4'h3;
        trig_valid = 1'b1;
        @(negedge clk);
        trig_valid = 1'b0;
        c = tb_cyc;
        repeat (2) @(negedge clk);
        check("R9 back to phys source", rd_data, word(c, 7));
        pop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_rising();
        t_falling();
        t_bubble();
        t_order_wrap();
        t_overflow();
        t_calib();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule